// File: doc/BRIEF.md
# MSI Doorbell to Interrupt Line Frame

This block is a 4 KB register frame that turns message-signalled interrupt writes into interrupt pulses. A device writes an absolute interrupt number to a doorbell register. The frame rebases that number against a window fixed at build time. If the result falls inside the window, one of up to 128 outgoing interrupt lines pulses high for a single clock cycle. The downstream interrupt controller latches the pulse as an edge.

Software finds the window by reading a read-only type register. That register reports the first interrupt number and the number of lines, both taken from the parameters. The frame also answers an interface identification register and a block of identification registers that read as zero.

The register bus is a plain synchronous port. It has an address, a write strobe, write data, an access size, a read strobe and registered read data. The frame always accepts an access in the cycle it is presented, so the bus has no back-pressure and no handshake. Read data is valid on the cycle after the read strobe.

Top module: `msi_doorbell_frame`

## Requirements
- R1: A 4-byte read of offset 0x008 returns (SPI_BASE + 32) in bits [31:16] and SPI_COUNT in bits [15:0].
- R2: A 4-byte read of offset 0xFCC returns 0x0510_0000. This is the product code 0x51 placed from bit 20 up, with every other field zero.
- R3: A read of any offset from 0xFD0 to 0xFFC returns zero. A read of any offset with no register decoded also returns zero.
- R4: The access size `bus_size` gives the byte count (1, 2, 4 or others). A read whose size is not 4 returns zero, even at a decoded offset.
- R5: Read data appears on `bus_rdata` in the cycle after the read strobe. It is zero in any cycle that follows a cycle with no read strobe, and it is zero after a synchronous reset.
- R6: A write to offset 0x040 uses bits [9:0] of the data as an interrupt number N. If SPI_BASE + 32 <= N < SPI_BASE + 32 + SPI_COUNT, line N - (SPI_BASE + 32) of `irq_pulse` is high for exactly the one cycle after the write.
- R7: A doorbell number outside that window raises no line. Data bits [31:10] are ignored.
- R8: A doorbell write has an effect only when `bus_size` is 2 or 4. A doorbell write of any other size raises no line.
- R9: A write to any offset other than 0x040 raises no line and leaves every read value unchanged.
- R10: Doorbell writes on consecutive cycles each produce their own one-cycle pulse, in the order of the writes.
- R11: At most one line of `irq_pulse` is high in any cycle.
- R12: Elaboration stops with an error if SPI_COUNT is 0 or above 128, or if SPI_BASE + 32 + SPI_COUNT exceeds 1020.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_addr | input | 12 | Byte offset within the frame |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_size | input | 3 | Access width in bytes |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |
| irq_pulse | output | SPI_COUNT | One-cycle interrupt pulses, one bit per line |

## Verification
The hardest cases to reach from the ports are the edges of the window, together with doorbell data whose upper bits are set. Upper bits must not move a number into the window or out of it. The bench instantiates a window that starts away from zero and writes the numbers just below the first line, the first line, the last line and one past the end. It also writes a value whose bits above bit 9 are set but whose low ten bits land in the window. Back-to-back doorbells are driven on consecutive cycles, and the bench samples each cycle, so that a pulse that is dropped, merged or stretched shows up as a wrong line.

// File: rtl/msi_frame_pkg.sv
package msi_frame_pkg;

  localparam int unsigned FRAME_AW   = 12;
  localparam int unsigned BUS_DW     = 32;
  localparam int unsigned SIZE_W     = 3;
  localparam int unsigned IRQ_NUM_W  = 10;
  localparam int unsigned LINE_LIMIT = 128;
  localparam int unsigned ID_CEILING = 1020;
  localparam int unsigned SHARED_OFS = 32;

  localparam logic [FRAME_AW-1:0] OFS_TYPE     = 12'h008;
  localparam logic [FRAME_AW-1:0] OFS_DOORBELL = 12'h040;
  localparam logic [FRAME_AW-1:0] OFS_IFACE_ID = 12'hFCC;
  localparam logic [FRAME_AW-1:0] OFS_IDBLK_LO = 12'hFD0;
  localparam logic [FRAME_AW-1:0] OFS_IDBLK_HI = 12'hFFC;

  localparam logic [7:0] PRODUCT_CODE = 8'h51;
  localparam int unsigned PRODUCT_LSB = 20;

  typedef enum logic [2:0] {
    RGN_NONE,
    RGN_TYPE,
    RGN_DOORBELL,
    RGN_IFACE_ID,
    RGN_IDBLK
  } region_e;

  function automatic logic [BUS_DW-1:0] iface_id_value();
    logic [BUS_DW-1:0] v;
    v = '0;
    v[PRODUCT_LSB +: 8] = PRODUCT_CODE;
    return v;
  endfunction

endpackage

// File: rtl/msi_frame_decode.sv
module msi_frame_decode
  import msi_frame_pkg::*;
(
  input  logic [FRAME_AW-1:0] addr,
  output region_e             region
);

  always_comb begin
    if (addr == OFS_TYPE) begin
      region = RGN_TYPE;
    end else if (addr == OFS_DOORBELL) begin
      region = RGN_DOORBELL;
    end else if (addr == OFS_IFACE_ID) begin
      region = RGN_IFACE_ID;
    end else if (addr >= OFS_IDBLK_LO && addr <= OFS_IDBLK_HI) begin
      region = RGN_IDBLK;
    end else begin
      region = RGN_NONE;
    end
  end

endmodule

// File: rtl/msi_frame_readmux.sv
module msi_frame_readmux
  import msi_frame_pkg::*;
#(
  parameter int unsigned SPI_BASE  = 0,
  parameter int unsigned SPI_COUNT = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_req,
  input  logic              rd_size_ok,
  input  region_e           region,
  output logic [BUS_DW-1:0] rdata
);

  localparam int unsigned FIRST_ID = SPI_BASE + SHARED_OFS;
  localparam logic [BUS_DW-1:0] TYPE_WORD =
    {16'(FIRST_ID), 16'(SPI_COUNT)};
  localparam logic [BUS_DW-1:0] IFACE_WORD = iface_id_value();

  logic [BUS_DW-1:0] rd_value;

  always_comb begin
    unique case (region)
      RGN_TYPE:     rd_value = TYPE_WORD;
      RGN_IFACE_ID: rd_value = IFACE_WORD;
      default:      rd_value = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata <= '0;
    end else if (rd_req && rd_size_ok) begin
      rdata <= rd_value;
    end else begin
      rdata <= '0;
    end
  end

endmodule

// File: rtl/msi_frame_doorbell.sv
module msi_frame_doorbell
  import msi_frame_pkg::*;
#(
  parameter int unsigned SPI_BASE  = 0,
  parameter int unsigned SPI_COUNT = 64
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ring,
  input  logic [IRQ_NUM_W-1:0] irq_num,
  output logic [SPI_COUNT-1:0] pulse
);

  localparam int unsigned FIRST_ID = SPI_BASE + SHARED_OFS;
  localparam int unsigned END_ID   = FIRST_ID + SPI_COUNT;
  localparam logic [IRQ_NUM_W:0] FIRST_EXT = (IRQ_NUM_W+1)'(FIRST_ID);
  localparam logic [IRQ_NUM_W:0] END_EXT   = (IRQ_NUM_W+1)'(END_ID);

  logic [IRQ_NUM_W:0]   num_ext;
  logic                 in_window;
  logic                 hit;
  logic [IRQ_NUM_W-1:0] line_ofs;

  assign num_ext   = {1'b0, irq_num};
  assign in_window = (num_ext >= FIRST_EXT) && (num_ext < END_EXT);
  assign hit       = ring && in_window;
  assign line_ofs  = irq_num - FIRST_EXT[IRQ_NUM_W-1:0];

  for (genvar i = 0; i < SPI_COUNT; i++) begin : g_line
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        pulse[i] <= 1'b0;
      end else begin
        pulse[i] <= hit && (line_ofs == IRQ_NUM_W'(i));
      end
    end
  end

endmodule

// File: rtl/msi_doorbell_frame.sv
module msi_doorbell_frame
  import msi_frame_pkg::*;
#(
  parameter int unsigned SPI_BASE  = 0,
  parameter int unsigned SPI_COUNT = 64
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [11:0]          bus_addr,
  input  logic                 bus_wr,
  input  logic [31:0]          bus_wdata,
  input  logic [2:0]           bus_size,
  input  logic                 bus_rd,
  output logic [31:0]          bus_rdata,
  output logic [SPI_COUNT-1:0] irq_pulse
);

  localparam int unsigned END_ID = SPI_BASE + SHARED_OFS + SPI_COUNT;

  // R12: legality of the configured window
  if (SPI_COUNT == 0 || SPI_COUNT > LINE_LIMIT) begin : g_bad_count
    $error("SPI_COUNT %0d outside 1..%0d", SPI_COUNT, LINE_LIMIT);
  end
  if (END_ID > ID_CEILING) begin : g_bad_window
    $error("interrupt window end %0d exceeds %0d", END_ID, ID_CEILING);
  end

  region_e region;
  logic    wr_size_ok;
  logic    rd_size_ok;
  logic    ring;
  logic    unused_wdata_hi;

  assign wr_size_ok      = (bus_size == 3'd2) || (bus_size == 3'd4);
  assign rd_size_ok      = (bus_size == 3'd4);
  assign ring            = bus_wr && wr_size_ok && (region == RGN_DOORBELL);
  assign unused_wdata_hi = ^bus_wdata[31:IRQ_NUM_W];

  msi_frame_decode u_decode (
    .addr   (bus_addr),
    .region (region)
  );

  msi_frame_readmux #(
    .SPI_BASE  (SPI_BASE),
    .SPI_COUNT (SPI_COUNT)
  ) u_readmux (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_req     (bus_rd),
    .rd_size_ok (rd_size_ok),
    .region     (region),
    .rdata      (bus_rdata)
  );

  msi_frame_doorbell #(
    .SPI_BASE  (SPI_BASE),
    .SPI_COUNT (SPI_COUNT)
  ) u_doorbell (
    .clk     (clk),
    .rst_n   (rst_n),
    .ring    (ring),
    .irq_num (bus_wdata[IRQ_NUM_W-1:0]),
    .pulse   (irq_pulse)
  );

endmodule

// File: rtl/msi_doorbell_frame_chk.sv
module msi_doorbell_frame_chk #(
  parameter int unsigned SPI_BASE  = 0,
  parameter int unsigned SPI_COUNT = 64
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [11:0]          bus_addr,
  input logic                 bus_wr,
  input logic [31:0]          bus_wdata,
  input logic [2:0]           bus_size,
  input logic                 bus_rd,
  input logic [31:0]          bus_rdata,
  input logic [SPI_COUNT-1:0] irq_pulse
);

  localparam int unsigned FIRST_ID = SPI_BASE + 32;
  localparam int unsigned END_ID   = FIRST_ID + SPI_COUNT;

  logic db_write;
  logic db_in_range;
  assign db_write    = bus_wr && bus_addr == 12'h040 && (bus_size == 3'd2 || bus_size == 3'd4);
  assign db_in_range = 32'(bus_wdata[9:0]) >= FIRST_ID && 32'(bus_wdata[9:0]) < END_ID;

  // R11
  one_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(irq_pulse));

  // R6
  pulse_after_ring_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (db_write && db_in_range) |=> $countones(irq_pulse) == 1);

  // R7
  no_stray_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(db_write && db_in_range) |=> irq_pulse == '0);

  // R5
  idle_rdata_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> bus_rdata == '0);

  // R4
  narrow_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_size != 3'd4) |=> bus_rdata == '0);

  // R1
  type_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_size == 3'd4 && bus_addr == 12'h008)
      |=> bus_rdata == {16'(FIRST_ID), 16'(SPI_COUNT)});

endmodule

bind msi_doorbell_frame msi_doorbell_frame_chk #(
  .SPI_BASE  (SPI_BASE),
  .SPI_COUNT (SPI_COUNT)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_addr  (bus_addr),
  .bus_wr    (bus_wr),
  .bus_wdata (bus_wdata),
  .bus_size  (bus_size),
  .bus_rd    (bus_rd),
  .bus_rdata (bus_rdata),
  .irq_pulse (irq_pulse)
);

// File: tb/msi_doorbell_frame_tb.sv
module msi_doorbell_frame_tb;

  localparam int unsigned BASE  = 16;
  localparam int unsigned COUNT = 40;
  localparam int unsigned FIRST = BASE + 32;      // 48
  localparam int unsigned LAST  = FIRST + COUNT - 1; // 87

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [11:0]      bus_addr = '0;
  logic             bus_wr = 1'b0;
  logic [31:0]      bus_wdata = '0;
  logic [2:0]       bus_size = 3'd4;
  logic             bus_rd = 1'b0;
  logic [31:0]      bus_rdata;
  logic [COUNT-1:0] irq_pulse;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  msi_doorbell_frame #(.SPI_BASE(BASE), .SPI_COUNT(COUNT)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_size(bus_size), .bus_rd(bus_rd),
    .bus_rdata(bus_rdata), .irq_pulse(irq_pulse)
  );

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [COUNT-1:0] line(input int n);
    logic [COUNT-1:0] v = '0;
    v[n] = 1'b1;
    return v;
  endfunction

  task automatic do_read(input logic [11:0] a, input logic [2:0] sz,
                         input logic [31:0] exp, input string req);
    bus_addr = a; bus_size = sz; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    check(req, 128'(bus_rdata), 128'(exp));
  endtask

  task automatic do_write(input logic [11:0] a, input logic [2:0] sz,
                          input logic [31:0] d, input logic [COUNT-1:0] exp,
                          input string req);
    bus_addr = a; bus_size = sz; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
    check(req, 128'(irq_pulse), 128'(exp));
    @(negedge clk);
    check({req, " cleared"}, 128'(irq_pulse), 128'(0));
  endtask

  task automatic t_reset;
    check("R5 reset rdata", 128'(bus_rdata), 128'(0));
    check("R6 reset pulse", 128'(irq_pulse), 128'(0));
  endtask

  task automatic t_reads;
    do_read(12'h008, 3'd4, 32'h0030_0028, "R1 type");
    do_read(12'hFCC, 3'd4, 32'h0510_0000, "R2 iface id");
    do_read(12'hFD0, 3'd4, 32'h0, "R3 idblk lo");
    do_read(12'hFFC, 3'd4, 32'h0, "R3 idblk hi");
    do_read(12'h100, 3'd4, 32'h0, "R3 undefined");
    do_read(12'h008, 3'd2, 32'h0, "R4 size 2");
    do_read(12'hFCC, 3'd1, 32'h0, "R4 size 1");
    // R5: data valid one cycle then returns to zero
    do_read(12'h008, 3'd4, 32'h0030_0028, "R5 latency");
    @(negedge clk);
    check("R5 idle zero", 128'(bus_rdata), 128'(0));
  endtask

  task automatic t_doorbell;
    do_write(12'h040, 3'd4, 32'(FIRST), line(0), "R6 first line");
    do_write(12'h040, 3'd2, 32'(LAST), line(COUNT-1), "R6 last line size2");
    do_write(12'h040, 3'd4, 32'(FIRST + 5), line(5), "R6 mid line");
    do_write(12'h040, 3'd4, 32'(FIRST - 1), '0, "R7 below window");
    do_write(12'h040, 3'd4, 32'(LAST + 1), '0, "R7 above window");
    do_write(12'h040, 3'd4, 32'hFFFF_FC00 | 32'(FIRST + 7), line(7), "R7 upper bits ignored");
    do_write(12'h040, 3'd4, 32'h0000_0400 | 32'(FIRST - 1), '0, "R7 upper bits no rescue");
  endtask

  task automatic t_sizes_offsets;
    do_write(12'h040, 3'd1, 32'(FIRST + 3), '0, "R8 size 1");
    do_write(12'h040, 3'd0, 32'(FIRST + 3), '0, "R8 size 0");
    do_write(12'h040, 3'd7, 32'(FIRST + 3), '0, "R8 size 7");
    do_write(12'h008, 3'd4, 32'h0000_0000, '0, "R9 write type");
    do_write(12'h044, 3'd4, 32'(FIRST + 3), '0, "R9 write near doorbell");
    do_read(12'h008, 3'd4, 32'h0030_0028, "R9 type unchanged");
    do_write(12'hFCC, 3'd4, 32'hFFFF_FFFF, '0, "R9 write iface");
    do_read(12'hFCC, 3'd4, 32'h0510_0000, "R9 iface unchanged");
  endtask

  task automatic t_back_to_back;
    bus_addr = 12'h040; bus_size = 3'd4; bus_wr = 1'b1;
    bus_wdata = 32'(FIRST + 2);
    @(negedge clk);
    check("R10 first pulse", 128'(irq_pulse), 128'(line(2)));
    check("R11 one line", 128'($countones(irq_pulse)), 128'(1));
    bus_wdata = 32'(FIRST + 9);
    @(negedge clk);
    check("R10 second pulse", 128'(irq_pulse), 128'(line(9)));
    bus_wdata = 32'(FIRST + 9);
    @(negedge clk);
    check("R10 repeat pulse", 128'(irq_pulse), 128'(line(9)));
    bus_wr = 1'b0;
    @(negedge clk);
    check("R10 train end", 128'(irq_pulse), 128'(0));
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_reads();
    t_doorbell();
    t_sizes_offsets();
    t_back_to_back();
    // R12 is enforced at elaboration; this legal window elaborates.
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule